// File: doc/BRIEF.md
# Eight-Channel Successive-Approximation Converter Controller

This block is the digital half of an eight-input successive-approximation analog-to-digital converter. A processor loads a 3-bit channel number into an address latch with a separate strobe. It then pulses a start line. The rising edge of start clears the approximation state and drops the end-of-conversion flag. The falling edge of start launches the conversion.

During a conversion the block presents the chosen channel to an external analog multiplexer. It also presents an 8-bit trial code to an external 256-step resistor ladder. For each trial it reads back one comparator bit. One bit is decided per clock, starting at the most significant bit. After eight decisions the final code is copied into a result register and the flag rises again, so the flag can serve as an interrupt. The result appears on an 8-bit bus that floats whenever output enable is low.

All inputs are sampled on the rising clock edge. The strobes are edge-detected against their value on the previous edge.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After synchronous reset, `eoc` is 1, `trial_code` is 0 and the result register is 0 (visible on `dout` while `oe` is 1).
- R2: The latched channel is loaded from `addr` only on the edge where `ale` is sampled high after being sampled low. Holding `ale` high while `addr` changes leaves the latched channel unchanged.
- R3: On the edge where `start` is first sampled high, `eoc` goes to 0 and `trial_code` goes to 0. Both stay there for as long as `start` stays high.
- R4: On the edge where `start` is first sampled low after a rise, conversion begins. `chan_sel` takes the latched channel and `trial_code` becomes 8'h80.
- R5: A conversion makes eight bit decisions, one per clock, from bit 7 down to bit 0. `eoc` rises on the ninth rising edge, counting from the edge that detects the start fall.
- R6: During each decision the trial bit is kept when `cmp_ge` is 1 and cleared when it is 0. With an ideal comparator, the result therefore equals the analog level in 8-bit steps. `dout[7]` is the MSB.
- R7: While `oe` is 0, `dout` is high-impedance, so another driver can own the bus. While `oe` is 1, `dout` drives the result register.
- R8: The result register changes only on the edge where `eoc` rises. Reads during a conversion return the previous result.
- R9: A new rising edge of `start` during a conversion aborts it. `eoc` stays 0, `trial_code` returns to 0, and a fresh conversion begins at the next falling edge.
- R10: The channel used by a conversion is fixed when `start` falls. An address strobe during the conversion changes neither `chan_sel` nor the result. It does take effect for the next conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address strobe; a rising edge captures `addr` |
| addr | input | 3 | Channel number |
| start | input | 1 | A rise arms and clears the converter; a fall starts conversion |
| oe | input | 1 | Result bus enable; 0 floats `dout` |
| cmp_ge | input | 1 | Comparator: 1 when the analog input is at or above the ladder level |
| chan_sel | output | 3 | Channel select to the analog multiplexer |
| trial_code | output | 8 | Code applied to the resistor ladder |
| eoc | output | 1 | End of conversion, low while armed or converting |
| dout | output | 8 | Tri-state result bus, bit 7 the MSB |

## Verification
Counting from the falling clock edge where the bench drives `start` high, `eoc` and `trial_code` change on the very next rising edge. The bench then drives `start` low. One rising edge later, `trial_code` is 8'h80 and `chan_sel` is valid. `eoc` and the new result follow nine rising edges after that drive. The bench drives all inputs on falling edges and samples outputs on falling edges. It counts those edges explicitly, so every check lands in the first half-cycle where a value is due. It also checks one edge before the `eoc` rise, to show that the flag and the held result do not move early.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ARMED = 2'd1,
    S_CONV  = 2'd2
  } sar_state_t;
endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det (
  input  logic clk,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic din_q;

  always_ff @(posedge clk) begin
    din_q <= din;
  end

  assign rise = din & ~din_q;
  assign fall = ~din & din_q;
endmodule

// File: rtl/sar_addr_latch.sv
module sar_addr_latch #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [CH_W-1:0] addr,
  output logic [CH_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= addr;
  end
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_rise,
  input  logic              start_fall,
  input  logic              cmp_ge,
  input  logic [CH_W-1:0]   addr_q,
  output logic [CH_W-1:0]   chan_q,
  output logic [DATA_W-1:0] sar_q,
  output logic [DATA_W-1:0] result_q,
  output logic              eoc_q
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0]  IDX_TOP = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0]  IDX_ONE = IDX_W'(1);
  localparam logic [DATA_W-1:0] MSB_ONE = {1'b1, {(DATA_W-1){1'b0}}};

  sar_state_t        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] code_nxt;

  // Resolve the current bit from the comparator and pre-set the next one.
  always_comb begin
    code_nxt         = sar_q;
    code_nxt[idx_q]  = cmp_ge;
    if (idx_q != '0) code_nxt[idx_q - IDX_ONE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      sar_q    <= '0;
      result_q <= '0;
      chan_q   <= '0;
      eoc_q    <= 1'b1;
    end else if (start_rise) begin
      state_q <= S_ARMED;
      idx_q   <= '0;
      sar_q   <= '0;
      eoc_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_ARMED: begin
          if (start_fall) begin
            state_q <= S_CONV;
            idx_q   <= IDX_TOP;
            sar_q   <= MSB_ONE;
            chan_q  <= addr_q;
          end
        end
        S_CONV: begin
          sar_q <= code_nxt;
          if (idx_q == '0) begin
            result_q <= code_nxt;
            eoc_q    <= 1'b1;
            state_q  <= S_IDLE;
          end else begin
            idx_q <= idx_q - IDX_ONE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int DATA_W = 8,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic [CH_W-1:0]   addr,
  input  logic              start,
  input  logic              oe,
  input  logic              cmp_ge,
  output logic [CH_W-1:0]   chan_sel,
  output logic [DATA_W-1:0] trial_code,
  output logic              eoc,
  output wire  [DATA_W-1:0] dout
);
  logic              ale_rise;
  logic              ale_fall;
  logic              start_rise;
  logic              start_fall;
  logic [CH_W-1:0]   addr_q;
  logic [DATA_W-1:0] result_q;

  sar_edge_det u_ale_edge (
    .clk (clk),
    .din (ale),
    .rise(ale_rise),
    .fall(ale_fall)
  );

  sar_edge_det u_start_edge (
    .clk (clk),
    .din (start),
    .rise(start_rise),
    .fall(start_fall)
  );

  sar_addr_latch #(.CH_W(CH_W)) u_addr (
    .clk   (clk),
    .rst   (rst),
    .load  (ale_rise),
    .addr  (addr),
    .addr_q(addr_q)
  );

  sar_engine #(.DATA_W(DATA_W), .CH_W(CH_W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .start_rise(start_rise),
    .start_fall(start_fall),
    .cmp_ge    (cmp_ge),
    .addr_q    (addr_q),
    .chan_q    (chan_sel),
    .sar_q     (trial_code),
    .result_q  (result_q),
    .eoc_q     (eoc)
  );

  assign dout = oe ? result_q : {DATA_W{1'bz}};

  logic unused_ok;
  assign unused_ok = ale_fall;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              eoc,
  input logic [CH_W-1:0]   chan_sel,
  input logic [DATA_W-1:0] trial_code,
  input logic [DATA_W-1:0] result_q
);
  localparam logic [DATA_W-1:0] MSB_ONE = {1'b1, {(DATA_W-1){1'b0}}};

  AST_EOC_CLEARED_BY_START: assert property (@(posedge clk) disable iff (rst)
    (start && !$past(start)) |=> !eoc); // R3

  AST_START_RISE_RESETS_CODE: assert property (@(posedge clk) disable iff (rst)
    (start && !$past(start)) |=> (trial_code == '0)); // R9

  AST_FALL_LOADS_MSB: assert property (@(posedge clk) disable iff (rst)
    (!eoc && $past(start) && !start) |=> (trial_code == MSB_ONE)); // R4

  AST_RESULT_HELD_IN_CONV: assert property (@(posedge clk) disable iff (rst)
    (!eoc && !$past(eoc)) |-> $stable(result_q)); // R8

  AST_CHANNEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!eoc && !$past(eoc) && !start && !$past(start) && !$past(start, 2))
      |-> $stable(chan_sel)); // R10
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.DATA_W(DATA_W), .CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .eoc       (eoc),
  .chan_sel  (chan_sel),
  .trial_code(trial_code),
  .result_q  (result_q)
);

// File: tb/sar_adc_ctrl_tb.sv
module sar_adc_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ale = 1'b0;
  logic [2:0] addr = '0;
  logic       start = 1'b0;
  logic       oe = 1'b1;
  logic       tb_drv = 1'b0;
  logic [2:0] chan_sel;
  logic [7:0] trial_code;
  logic       eoc;
  wire  [7:0] bus;
  logic [7:0] ch_val [8];
  logic       cmp_ge;
  logic [7:0] last_res = 8'h00;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  assign cmp_ge = (ch_val[chan_sel] >= trial_code);
  assign bus    = tb_drv ? 8'h3C : 8'bz;

  sar_adc_ctrl u_dut (
    .clk(clk), .rst(rst), .ale(ale), .addr(addr), .start(start), .oe(oe),
    .cmp_ge(cmp_ge), .chan_sel(chan_sel), .trial_code(trial_code),
    .eoc(eoc), .dout(bus)
  );

  // {channel, analog level}
  localparam logic [10:0] VEC [8] = '{
    {3'd5, 8'hAA}, {3'd0, 8'h00}, {3'd7, 8'hC3}, {3'd1, 8'hFF},
    {3'd3, 8'h7F}, {3'd2, 8'h80}, {3'd6, 8'h01}, {3'd4, 8'h55}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic latch_addr(input logic [2:0] a);
    addr = a; ale = 1'b1;
    @(negedge clk); ale = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_conv(input logic [2:0] ch, input logic [7:0] exp,
                          input bit mid_ale, input logic [2:0] mid_addr);
    start = 1'b1;
    @(negedge clk);
    chk("R3 eoc low after start rise", eoc, 1'b0);
    chk("R3 code cleared", trial_code, 8'h00);
    start = 1'b0;
    @(negedge clk);
    chk("R4 first trial", trial_code, 8'h80);
    chk("R4 channel", chan_sel, ch);
    if (mid_ale) begin addr = mid_addr; ale = 1'b1; end
    @(negedge clk);
    ale = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5 eoc still low before 9th edge", eoc, 1'b0);
    chk("R8 old result during conversion", bus, last_res);
    chk("R10 channel held", chan_sel, ch);
    @(negedge clk);
    chk("R5 eoc high on 9th edge", eoc, 1'b1);
    chk("R6 result", bus, exp);
    last_res = exp;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) ch_val[VEC[i][10:8]] = VEC[i][7:0];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 eoc after reset", eoc, 1'b1);
    chk("R1 code after reset", trial_code, 8'h00);
    chk("R1 result after reset", bus, 8'h00);

    // Table walk: every channel with its own level (R6 MSB order, R2 strobe).
    for (int i = 0; i < 8; i++) begin
      latch_addr(VEC[i][10:8]);
      run_conv(VEC[i][10:8], VEC[i][7:0], 1'b0, 3'd0);
    end

    // R2: address moves while strobe stays high -> no new capture.
    addr = 3'd3; ale = 1'b1;
    @(negedge clk); addr = 3'd5;
    @(negedge clk); ale = 1'b0;
    @(negedge clk);
    run_conv(3'd3, ch_val[3], 1'b0, 3'd0);

    // R10: strobe during conversion ignored now, used next time.
    latch_addr(3'd2);
    run_conv(3'd2, ch_val[2], 1'b1, 3'd6);
    run_conv(3'd6, ch_val[6], 1'b0, 3'd0);

    // R9: restart aborts a conversion in progress.
    latch_addr(3'd1);
    start = 1'b1; @(negedge clk);
    start = 1'b0; repeat (4) @(negedge clk);
    start = 1'b1; @(negedge clk);
    chk("R9 eoc low on restart", eoc, 1'b0);
    chk("R9 code cleared on restart", trial_code, 8'h00);
    repeat (3) @(negedge clk);
    chk("R3 eoc held low while start high", eoc, 1'b0);
    chk("R9 code held at zero", trial_code, 8'h00);
    chk("R9 old result kept", bus, last_res);
    start = 1'b0;
    repeat (8) @(negedge clk);
    chk("R9 eoc low before new finish", eoc, 1'b0);
    @(negedge clk);
    chk("R9 eoc after restarted conversion", eoc, 1'b1);
    chk("R9 result after restart", bus, ch_val[1]);
    last_res = ch_val[1];

    // R7: floating bus can be taken by another driver.
    oe = 1'b0; tb_drv = 1'b1;
    @(negedge clk);
    chk("R7 bus released when oe low", bus, 8'h3C);
    tb_drv = 1'b0; oe = 1'b1;
    @(negedge clk);
    chk("R7 result driven when oe high", bus, last_res);

    finish_run();
  end
endmodule